// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a page table tree held in ordinary memory. Each translation request carries a process context number together with the virtual address. The context number picks one slot in a context table at a fixed memory base. That slot points at the process's top-level table, whose entry points at a middle-level table, whose entry points at a leaf table. The leaf entry gives the physical frame number and three permission bits. The frame number is then joined to the untranslated page offset.

The walker issues one memory read for each of the four lookups and never has more than one read in flight. When any entry it reads is marked invalid, the walk stops at once and a fault pulse reports which lookup failed. A successful walk ends with a done pulse and the physical address. Switching processes needs nothing more than a different context number on the next request. The walker accepts a new request only when it is idle.

Top module: `ptw3_walker`

## Requirements
- R1: On success, `paddr` is the leaf entry's bits [31:12] as the frame number, placed above bits [11:0] of the virtual address, which pass through unchanged.
- R2: The first read goes to `CTX_BASE + 4*ctx`, where `ctx` is the `req_ctx` value taken when the request is accepted. Later changes on `req_ctx` or `req_vaddr` have no effect on a walk already in progress.
- R3: Entry bit 0 is the valid flag. A valid context, top or middle entry gives the next table base as the entry with bits [1:0] cleared. The top, middle and leaf reads go to base + 4*index, and the indices are virtual address bits [31:24], [23:18] and [17:12]. Every read address is word aligned.
- R4: A successful walk makes exactly four reads. `mem_req` is a one-cycle pulse, and the next pulse comes only after `mem_rvalid` has returned the previous read's data.
- R5: An entry with bit 0 clear ends the walk with a `fault` pulse. `fault_lvl` then gives 0 for the context slot, 1 for the top table, 2 for the middle table and 3 for the leaf table. No further read is issued for that walk, so the walk makes `fault_lvl`+1 reads.
- R6: On success, `done` pulses for one cycle, and `perm` carries leaf entry bits [3:1] in that cycle.
- R7: `req_ready` is high only while the walker is idle. A `req_valid` seen while `req_ready` is low is ignored and produces no result.
- R8: After reset, `req_ready` is high and `mem_req`, `done` and `fault` are low.
- R9: A `mem_rvalid` that arrives while no read is outstanding is ignored.
- R10: `done` and `fault` are never high together. In the cycle after either pulse, the walker is idle again with both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | CTX_W | Process context number |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Read address, valid with mem_req |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned table entry |
| done | output | 1 | Successful walk pulse |
| fault | output | 1 | Failed walk pulse |
| fault_lvl | output | 2 | Failing lookup, valid with fault |
| paddr | output | 32 | Physical address, valid with done |
| perm | output | 3 | Leaf permission bits, valid with done |

## Verification
A wrong state or a wrong saved base shows within one read: the next `mem_addr` points at the wrong slot, so the data that comes back builds a wrong physical address or a fault at the wrong level. The bench's memory model serves a table tree that it builds itself. It counts the reads between acceptance and the result, so a walk that skips a level or runs on past a fault is caught in the same walk. A lost or stuck pending flag shows up as a missing pulse or an extra read, and the bench sees it before the next request.

// File: rtl/ptw3_pkg.sv
package ptw3_pkg;

    localparam int AW    = 32;
    localparam int OFF_W = 12;
    localparam int I1_W  = 8;
    localparam int I2_W  = 6;
    localparam int I3_W  = 6;
    localparam int FRM_W = AW - OFF_W;
    localparam int ENT_B = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTX,
        ST_TOP,
        ST_MID,
        ST_LEAF,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef struct packed {
        logic [I1_W-1:0]  i1;
        logic [I2_W-1:0]  i2;
        logic [I3_W-1:0]  i3;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    typedef struct packed {
        logic [FRM_W-1:0]   frame;
        logic [OFF_W-5:0]   rsvd;
        logic [2:0]         perm;
        logic               valid;
    } leaf_t;

    function automatic logic ent_ok(input logic [AW-1:0] e);
        return e[0];
    endfunction

    function automatic logic [AW-1:0] ent_base(input logic [AW-1:0] e);
        return {e[AW-1:2], 2'b00};
    endfunction

    function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                                 input logic [AW-1:0] idx);
        return base + (idx * ENT_B);
    endfunction

    function automatic logic is_read_st(input walk_st_e s);
        return (s == ST_CTX) || (s == ST_TOP) || (s == ST_MID) || (s == ST_LEAF);
    endfunction

    function automatic logic [1:0] st_level(input walk_st_e s);
        case (s)
            ST_TOP:  return 2'd1;
            ST_MID:  return 2'd2;
            ST_LEAF: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ptw3_addr_gen.sv
module ptw3_addr_gen
    import ptw3_pkg::*;
#(
    parameter int          CTX_W    = 12,
    parameter logic [31:0] CTX_BASE = 32'h0001_0000
) (
    input  walk_st_e           state,
    input  vaddr_t             va,
    input  logic [CTX_W-1:0]   ctx,
    input  logic [AW-1:0]      tbl_base,
    output logic [AW-1:0]      addr
);

    logic [AW-1:0] base_sel;
    logic [AW-1:0] idx_sel;

    always_comb begin
        base_sel = tbl_base;
        idx_sel  = '0;
        case (state)
            ST_CTX: begin
                base_sel = CTX_BASE;
                idx_sel  = AW'(ctx);
            end
            ST_TOP:  idx_sel = AW'(va.i1);
            ST_MID:  idx_sel = AW'(va.i2);
            ST_LEAF: idx_sel = AW'(va.i3);
            default: begin
                base_sel = '0;
                idx_sel  = '0;
            end
        endcase
        addr = slot_addr(base_sel, idx_sel);
    end

endmodule

// File: rtl/ptw3_fsm.sv
module ptw3_fsm
    import ptw3_pkg::*;
#(
    parameter int CTX_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_vaddr,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              rsp_valid,
    input  logic [AW-1:0]     rsp_data,
    output walk_st_e          state,
    output vaddr_t            va,
    output logic [CTX_W-1:0]  ctx,
    output logic [AW-1:0]     tbl_base,
    output logic              rd_issue,
    output logic              leaf_load,
    output logic              fault_load,
    output logic [1:0]        cur_lvl,
    output logic              idle,
    output logic              done_p,
    output logic              fault_p
);

    logic pending;
    logic rsp_take;

    assign rd_issue   = is_read_st(state) && !pending;
    assign rsp_take   = is_read_st(state) && pending && rsp_valid;
    assign leaf_load  = rsp_take && (state == ST_LEAF) && ent_ok(rsp_data);
    assign fault_load = rsp_take && !ent_ok(rsp_data);
    assign cur_lvl    = st_level(state);
    assign idle       = (state == ST_IDLE);
    assign done_p     = (state == ST_DONE);
    assign fault_p    = (state == ST_FAULT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pending  <= 1'b0;
            va       <= '0;
            ctx      <= '0;
            tbl_base <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va      <= vaddr_t'(req_vaddr);
                        ctx     <= req_ctx;
                        pending <= 1'b0;
                        state   <= ST_CTX;
                    end
                end
                ST_CTX, ST_TOP, ST_MID, ST_LEAF: begin
                    if (!pending) begin
                        pending <= 1'b1;
                    end else if (rsp_valid) begin
                        pending <= 1'b0;
                        if (!ent_ok(rsp_data)) begin
                            state <= ST_FAULT;
                        end else begin
                            tbl_base <= ent_base(rsp_data);
                            case (state)
                                ST_CTX:  state <= ST_TOP;
                                ST_TOP:  state <= ST_MID;
                                ST_MID:  state <= ST_LEAF;
                                default: state <= ST_DONE;
                            endcase
                        end
                    end
                end
                ST_DONE, ST_FAULT: state <= ST_IDLE;
                default:           state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ptw3_result.sv
module ptw3_result
    import ptw3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              leaf_load,
    input  logic              fault_load,
    input  logic [1:0]        lvl_in,
    input  logic [AW-1:0]     leaf_word,
    input  logic [OFF_W-1:0]  offset,
    output logic [AW-1:0]     paddr,
    output logic [2:0]        perm,
    output logic [1:0]        fault_lvl
);

    leaf_t leaf;
    assign leaf = leaf_t'(leaf_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            paddr     <= '0;
            perm      <= '0;
            fault_lvl <= '0;
        end else begin
            if (leaf_load) begin
                paddr <= {leaf.frame, offset};
                perm  <= leaf.perm;
            end
            if (fault_load) begin
                fault_lvl <= lvl_in;
            end
        end
    end

endmodule

// File: rtl/ptw3_walker.sv
module ptw3_walker
    import ptw3_pkg::*;
#(
    parameter int          CTX_W    = 12,
    parameter logic [31:0] CTX_BASE = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic [CTX_W-1:0]  req_ctx,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_lvl,
    output logic [31:0]       paddr,
    output logic [2:0]        perm
);

    walk_st_e          state;
    vaddr_t            va;
    logic [CTX_W-1:0]  ctx;
    logic [AW-1:0]     tbl_base;
    logic              leaf_load;
    logic              fault_load;
    logic [1:0]        cur_lvl;

    ptw3_fsm #(.CTX_W(CTX_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .req_ctx    (req_ctx),
        .rsp_valid  (mem_rvalid),
        .rsp_data   (mem_rdata),
        .state      (state),
        .va         (va),
        .ctx        (ctx),
        .tbl_base   (tbl_base),
        .rd_issue   (mem_req),
        .leaf_load  (leaf_load),
        .fault_load (fault_load),
        .cur_lvl    (cur_lvl),
        .idle       (req_ready),
        .done_p     (done),
        .fault_p    (fault)
    );

    ptw3_addr_gen #(.CTX_W(CTX_W), .CTX_BASE(CTX_BASE)) u_addr (
        .state    (state),
        .va       (va),
        .ctx      (ctx),
        .tbl_base (tbl_base),
        .addr     (mem_addr)
    );

    ptw3_result u_res (
        .clk        (clk),
        .rst        (rst),
        .leaf_load  (leaf_load),
        .fault_load (fault_load),
        .lvl_in     (cur_lvl),
        .leaf_word  (mem_rdata),
        .offset     (va.off),
        .paddr      (paddr),
        .perm       (perm),
        .fault_lvl  (fault_lvl)
    );

endmodule

// File: rtl/ptw3_walker_chk.sv
module ptw3_walker_chk #(
    parameter int CTX_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req,
    input logic [31:0]       mem_addr,
    input logic              done,
    input logic              fault
);

    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready); // R7

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R7

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R4

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R3

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done && fault)); // R10

    AST_PULSE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (done || fault) |=> (req_ready && !done && !fault)); // R10

    AST_NO_READ_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done || fault) |-> !mem_req); // R5

endmodule

bind ptw3_walker ptw3_walker_chk #(.CTX_W(CTX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .done      (done),
    .fault     (fault)
);

// File: tb/ptw3_walker_bench.sv
module ptw3_walker_bench;

    localparam int          CTX_W    = 12;
    localparam logic [31:0] CTX_BASE = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [31:0]       req_vaddr = '0;
    logic [CTX_W-1:0]  req_ctx = '0;
    logic              mem_req;
    logic [31:0]       mem_addr;
    logic              mdl_rv = 1'b0;
    logic              stray_rv = 1'b0;
    logic              mem_rvalid;
    logic [31:0]       mdl_data = '0;
    logic [31:0]       stray_data = '0;
    logic [31:0]       mem_rdata;
    logic              done;
    logic              fault;
    logic [1:0]        fault_lvl;
    logic [31:0]       paddr;
    logic [2:0]        perm;

    assign mem_rvalid = mdl_rv | stray_rv;
    assign mem_rdata  = stray_rv ? stray_data : mdl_data;

    always #2 clk = ~clk;

    ptw3_walker #(.CTX_W(CTX_W), .CTX_BASE(CTX_BASE)) u_ptw3_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_ctx(req_ctx), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .fault_lvl(fault_lvl), .paddr(paddr),
        .perm(perm)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_issued = 0;
    int n_result = 0;
    int reads_cur = 0;
    logic finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model and table builder
    logic [31:0] mem [int unsigned];
    logic [31:0] next_top = 32'h0010_0000;
    logic [31:0] next_sub = 32'h0020_0000;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic map_page(input int ctx, input logic [31:0] va,
                            input logic [19:0] frame, input logic [2:0] pm);
        logic [31:0] a, e;
        a = CTX_BASE + ctx * 4;
        e = rd(a);
        if (!e[0]) begin e = next_top | 32'h1; mem[a] = e; next_top += 32'h400; end
        a = {e[31:2], 2'b00} + va[31:24] * 4;
        e = rd(a);
        if (!e[0]) begin e = next_sub | 32'h1; mem[a] = e; next_sub += 32'h100; end
        a = {e[31:2], 2'b00} + va[23:18] * 4;
        e = rd(a);
        if (!e[0]) begin e = next_sub | 32'h1; mem[a] = e; next_sub += 32'h100; end
        a = {e[31:2], 2'b00} + va[17:12] * 4;
        mem[a] = {frame, 8'h00, pm, 1'b1};
    endtask

    typedef struct {
        bit          flt;
        logic [1:0]  lvl;
        logic [31:0] pa;
        logic [2:0]  pm;
        int          nrd;
        string       tag;
    } exp_t;

    exp_t sb[$];

    function automatic exp_t ref_walk(input int ctx, input logic [31:0] va, input string tag);
        exp_t r;
        logic [31:0] e;
        r.tag = tag; r.flt = 0; r.lvl = 0; r.pa = 0; r.pm = 0;
        e = rd(CTX_BASE + ctx * 4); r.nrd = 1;
        if (!e[0]) begin r.flt = 1; r.lvl = 0; return r; end
        e = rd({e[31:2], 2'b00} + va[31:24] * 4); r.nrd = 2;
        if (!e[0]) begin r.flt = 1; r.lvl = 1; return r; end
        e = rd({e[31:2], 2'b00} + va[23:18] * 4); r.nrd = 3;
        if (!e[0]) begin r.flt = 1; r.lvl = 2; return r; end
        e = rd({e[31:2], 2'b00} + va[17:12] * 4); r.nrd = 4;
        if (!e[0]) begin r.flt = 1; r.lvl = 3; return r; end
        r.pa = {e[31:12], va[11:0]};
        r.pm = e[3:1];
        return r;
    endfunction

    int lat_sel = 0;
    initial begin
        forever begin
            @(negedge clk);
            mdl_rv = 1'b0;
            if (mem_req && !rst) begin
                logic [31:0] a;
                a = mem_addr;
                reads_cur++;
                repeat (1 + (lat_sel % 3)) @(negedge clk);
                lat_sel++;
                mdl_data = rd(a);
                mdl_rv   = 1'b1;
            end
        end
    end

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (done || fault)) begin
                exp_t x;
                n_result++;
                if (sb.size() == 0) begin
                    check(0, "R7 unexpected result", 64'(n_result), 64'(n_issued));
                end else begin
                    x = sb.pop_front();
                    check(fault == x.flt && done == !x.flt, {x.tag, " R5/R6 outcome"},
                          64'({done, fault}), 64'({!x.flt, x.flt}));
                    if (x.flt)
                        check(fault_lvl == x.lvl, {x.tag, " R5 fault level"}, 64'(fault_lvl), 64'(x.lvl));
                    else begin
                        check(paddr == x.pa, {x.tag, " R1 paddr"}, 64'(paddr), 64'(x.pa));
                        check(perm == x.pm, {x.tag, " R6 perm"}, 64'(perm), 64'(x.pm));
                    end
                    check(reads_cur == x.nrd, {x.tag, " R4 read count"}, 64'(reads_cur), 64'(x.nrd));
                end
                reads_cur = 0;
                @(negedge clk);
                check(req_ready && !done && !fault, "R10 idle after pulse",
                      64'({req_ready, done, fault}), 64'(3'b100));
            end
        end
    end

    task automatic issue(input int ctx, input logic [31:0] va, input string tag,
                         input bit poke_busy);
        sb.push_back(ref_walk(ctx, va, tag));
        n_issued++;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_ctx   = CTX_W'(ctx);
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        // R2: change request inputs during the walk
        req_ctx   = ~CTX_W'(ctx);
        req_vaddr = ~va;
        if (poke_busy) begin
            req_valid = 1'b1;
            @(negedge clk);
            check(!req_ready, "R7 ready low while busy", 64'(req_ready), 64'(0));
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!req_ready || done || fault) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired R4 actual=hang expected=completion");
        finish_up();
    end

    initial begin
        map_page(5, 32'h1234_5678, 20'hABCDE, 3'b101);
        map_page(5, 32'h1234_6ABC, 20'h00042, 3'b010);
        map_page(9, 32'h1234_5678, 20'h77777, 3'b111);
        map_page(4095, 32'hFFFF_FFFF, 20'hFFFFF, 3'b001);
        map_page(0, 32'h0000_0000, 20'h00001, 3'b100);

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R8 ready in reset", 64'(req_ready), 64'(1));
        check(!mem_req && !done && !fault, "R8 outputs quiet in reset",
              64'({mem_req, done, fault}), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !mem_req && !done && !fault, "R8 idle after reset",
              64'({req_ready, mem_req, done, fault}), 64'(4'b1000));

        // R9: stray read data while idle
        stray_data = 32'hFFFF_FFFF;
        stray_rv = 1'b1;
        @(negedge clk);
        stray_rv = 1'b0;
        check(req_ready && !done && !fault, "R9 stray rvalid ignored",
              64'({req_ready, done, fault}), 64'(3'b100));

        issue(5, 32'h1234_5678, "R1 R3 basic walk", 0);
        issue(5, 32'h1234_6ABC, "R3 neighbour leaf", 1);
        issue(9, 32'h1234_5678, "R2 other context", 0);
        issue(4095, 32'hFFFF_FFFF, "R2 R3 top indices", 0);
        issue(0, 32'h0000_0000, "R3 zero indices", 0);
        issue(7, 32'h1234_5678, "R5 context slot invalid", 0);
        issue(5, 32'h1300_0000, "R5 top entry invalid", 0);
        issue(5, 32'h1280_0000, "R5 middle entry invalid", 0);
        issue(5, 32'h1234_7000, "R5 leaf entry invalid", 1);
        issue(9, 32'h1234_5FFF, "R1 offset passthrough", 0);

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7 all results seen", 64'(sb.size()), 64'(0));
        check(n_result == n_issued, "R7 result count", 64'(n_result), 64'(n_issued));
        finish_up();
    end

endmodule